// File: doc/BRIEF.md
# Keyed Per-Line Software Reset Controller

This block lets software hold individual peripheral blocks in reset. It drives a vector of up to 24 reset lines, each controlled by its own bit in a line-control register. A line is only driven when it has also been unlocked in a separate line-enable register. This gives two guards against a stray write: the control register changes only when the top byte of the write carries a fixed key, and a line that has not been unlocked stays released even if its control bit is set.

Software follows a fixed order. To assert a line, it first sets the line's enable bit and then writes the control bit together with the key. To release a line, it clears the control bit and then clears the enable bit. The enable register can be left out through a parameter. In that case every enable bit reads as 1 and the control register alone decides the outputs.

Access is through a simple 32-bit register port. Writes are captured on the clock edge, and reads are combinational from the address. Bringing the reset outputs into each target's clock domain is left to the receiving logic.

Top module: `swrst_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every control bit and every stored enable bit, so all reset outputs are deasserted (0) and both registers read back as zero (an absent enable register still reads as all ones).
- R2: A write to offset 0x18 whose bits [31:24] equal 0x88 loads bits [LINES-1:0] of the write data into the control register on that clock edge; bit n controls line n, and 1 means asserted.
- R3: A write to offset 0x18 whose bits [31:24] differ from 0x88 leaves the control register and all outputs unchanged.
- R4: A write to offset 0xFC loads bits [LINES-1:0] into the enable register whatever the top byte holds; no key is needed, and data bits at or above LINES are dropped.
- R5: Reset output n is 1 exactly when control bit n and enable bit n are both 1.
- R6: A read of offset 0x18 returns the stored control bits in [LINES-1:0], with the key byte [31:24] and all other upper bits read as zero.
- R7: A read of offset 0xFC returns the stored enable bits; when the enable register is configured as absent, it returns ones in [LINES-1:0] and writes to 0xFC have no effect.
- R8: Writes to any other offset change neither register, and reads of any other offset return zero.
- R9: Clearing an enable bit while its control bit is still set releases that line at once but keeps the control bit stored, so setting the enable bit again reasserts the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data; bits [31:24] carry the key for the control register |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_out | output | LINES | Per-line reset outputs, 1 = asserted |

## Verification
The bench runs one instance with the enable register present and a second, 8-line instance with it absent. Both share one bus, so a single write exercises both configurations. It tries keys that are one bit off and keys with a zero top byte; a design that compared fewer key bits, or no key bits, would load these writes and change its outputs. It clears an enable bit under a set control bit and then sets it again. A design that cleared the control bit, or ignored the enable mask, would show a wrong output vector, or a wrong control read-back, there. It also writes and reads neighbouring offsets and sets all-ones data patterns. A loose address decode, a key byte leaking into read data, or data bits above the line count sneaking into storage would each appear as a mismatch.

// File: rtl/swrst_pkg.sv
// Package: shared constants and types for the keyed software reset controller.
// Assumes 32-bit register accesses with the write key in the top byte.
package swrst_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned KEY_LSB = 24;
    localparam int unsigned KEY_W   = 8;
    localparam logic [KEY_W-1:0] WR_KEY = 8'h88;
    localparam int unsigned MAX_LINES = 24;

    // Which register an access targets.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_EN   = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/swrst_decode.sv
// Module: swrst_decode
// Maps a byte offset onto the register it selects. Assumes exact-match decode;
// every offset other than the two listed selects nothing.
module swrst_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h18,
    parameter logic [ADDR_W-1:0] EN_OFS   = 8'hFC
) (
    input  logic [ADDR_W-1:0]  addr,
    output swrst_pkg::reg_sel_e sel
);
    import swrst_pkg::*;

    // Exact-match address compare.
    always_comb begin
        if (addr == CTRL_OFS)    sel = SEL_CTRL;
        else if (addr == EN_OFS) sel = SEL_EN;
        else                     sel = SEL_NONE;
    end
endmodule

// File: rtl/swrst_ctrl_reg.sv
// Module: swrst_ctrl_reg
// Holds one control bit per reset line. A load happens only when the write is
// selected and its key byte matches. Assumes a synchronous active-low reset.
module swrst_ctrl_reg #(
    parameter int unsigned LINES = 24
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_sel,
    input  logic [swrst_pkg::KEY_W-1:0]         wr_key,
    input  logic [LINES-1:0]                    wr_bits,
    output logic [LINES-1:0]                    ctrl_q
);
    import swrst_pkg::*;

    logic key_ok;

    // Key comparison gates every control update.
    always_comb key_ok = (wr_key == WR_KEY);

    // Control storage: clear on reset, load on a keyed write.
    always_ff @(posedge clk) begin
        if (!rst_n)                ctrl_q <= '0;
        else if (wr_sel && key_ok) ctrl_q <= wr_bits;
    end
endmodule

// File: rtl/swrst_en_reg.sv
// Module: swrst_en_reg
// Per-line enable mask. When HAS_EN is 0 there is no storage and every line
// reads as enabled. Assumes a synchronous active-low reset.
module swrst_en_reg #(
    parameter int unsigned LINES  = 24,
    parameter bit          HAS_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [LINES-1:0] wr_bits,
    output logic [LINES-1:0] en_q
);
    generate
        if (HAS_EN) begin : g_store
            // Enable storage: clear on reset, load on any selected write.
            always_ff @(posedge clk) begin
                if (!rst_n)      en_q <= '0;
                else if (wr_sel) en_q <= wr_bits;
            end
        end else begin : g_absent
            logic unused_in;
            // No storage: inputs are deliberately dropped.
            always_comb unused_in = ^{clk, rst_n, wr_sel, wr_bits};
            // Every line reads as enabled.
            always_comb en_q = '1;
        end
    endgenerate
endmodule

// File: rtl/swrst_ctrl.sv
// Module: swrst_ctrl (top)
// Keyed per-line software reset controller. A line is driven when both its
// control bit and its enable bit are set. Assumes LINES between 1 and 24 and
// that targets synchronise rst_out into their own clock domains.
module swrst_ctrl #(
    parameter int unsigned LINES  = 24,
    parameter bit          HAS_EN = 1'b1,
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h18,
    parameter logic [ADDR_W-1:0] EN_OFS   = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [LINES-1:0]  rst_out
);
    import swrst_pkg::*;

    localparam int unsigned KEY_MSB = KEY_LSB + KEY_W - 1;

    reg_sel_e         sel;
    logic [LINES-1:0] ctrl_q;
    logic [LINES-1:0] en_eff;
    logic             unused_wdata;

    // Data bits between LINES and the key byte are never stored.
    always_comb unused_wdata = ^bus_wdata;

    swrst_decode #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS),
        .EN_OFS  (EN_OFS)
    ) i_decode (
        .addr(bus_addr),
        .sel (sel)
    );

    swrst_ctrl_reg #(
        .LINES(LINES)
    ) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (bus_wr && (sel == SEL_CTRL)),
        .wr_key (bus_wdata[KEY_MSB:KEY_LSB]),
        .wr_bits(bus_wdata[LINES-1:0]),
        .ctrl_q (ctrl_q)
    );

    swrst_en_reg #(
        .LINES (LINES),
        .HAS_EN(HAS_EN)
    ) i_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (bus_wr && (sel == SEL_EN)),
        .wr_bits(bus_wdata[LINES-1:0]),
        .en_q   (en_eff)
    );

    // Read mux: zero-extended line bits, key byte always zero.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: bus_rdata[LINES-1:0] = ctrl_q;
            SEL_EN:   bus_rdata[LINES-1:0] = en_eff;
            default:  bus_rdata = '0;
        endcase
    end

    // Reset outputs need both the control bit and the enable bit.
    always_comb rst_out = ctrl_q & en_eff;
endmodule

// File: rtl/swrst_ctrl_chk.sv
// Module: swrst_ctrl_chk
// Property checker bound to swrst_ctrl. Observes the bus, the outputs and the
// two stored vectors; it drives nothing.
module swrst_ctrl_chk #(
    parameter int unsigned LINES  = 24,
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h18,
    parameter logic [ADDR_W-1:0] EN_OFS   = 8'hFC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [LINES-1:0]  rst_out,
    input logic [LINES-1:0]  ctrl_q,
    input logic [LINES-1:0]  en_eff
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0) && (rst_out == '0));

    // R2
    keyed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_OFS && bus_wdata[31:24] == 8'h88)
        |=> ctrl_q == $past(bus_wdata[LINES-1:0]));

    // R3
    bad_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_OFS && bus_wdata[31:24] != 8'h88)
        |=> $stable(ctrl_q));

    // R5
    out_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rst_out & ~ctrl_q) == '0) && ((rst_out & ~en_eff) == '0));

    // R6
    key_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CTRL_OFS) |-> (bus_rdata[31:24] == 8'h00));

    // R8
    other_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != CTRL_OFS && bus_addr != EN_OFS)
        |=> $stable(ctrl_q) && $stable(en_eff));
endmodule

bind swrst_ctrl swrst_ctrl_chk #(
    .LINES   (LINES),
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .EN_OFS  (EN_OFS)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .rst_out  (rst_out),
    .ctrl_q   (ctrl_q),
    .en_eff   (en_eff)
);

// File: tb/test_swrst_ctrl.sv
// Bench for swrst_ctrl: a 24-line instance with enable storage and an 8-line
// instance without it share one bus. A behavioural model is compared every cycle.
module test_swrst_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata, bus_rdata2;
    logic [23:0] rst_out;
    logic [7:0]  rst_out2;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model state
    int unsigned m_ctrl = 0, m_en = 0, m_ctrl2 = 0;

    always #10 clk = ~clk;

    swrst_ctrl #(.LINES(24), .HAS_EN(1'b1)) i_swrst_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_out(rst_out));

    swrst_ctrl #(.LINES(8), .HAS_EN(1'b0)) i_swrst_ctrl_noen (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata2), .rst_out(rst_out2));

    // Model update at the capturing edge (inputs change only on falling edges)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_en = 0; m_ctrl2 = 0;
        end else if (bus_wr) begin
            if (bus_addr == 8'h18 && bus_wdata[31:24] == 8'h88) begin
                m_ctrl  = bus_wdata & 32'h00FF_FFFF;
                m_ctrl2 = bus_wdata & 32'h0000_00FF;
            end else if (bus_addr == 8'hFC) begin
                m_en = bus_wdata & 32'h00FF_FFFF;
            end
        end
    end

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R5: outputs compared with the model on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            check("R5 rst_out", 32'(rst_out), m_ctrl & m_en);
            check("R5 rst_out no-enable", 32'(rst_out2), m_ctrl2);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag,
                      input int unsigned exp, input int unsigned exp2);
        @(negedge clk);
        bus_addr = a;
        #2;
        check(tag, bus_rdata, exp);
        check({tag, " no-enable"}, bus_rdata2, exp2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(8'h18, "R1 ctrl after reset", 0, 0);
        rd(8'hFC, "R1/R7 enable after reset", 0, 32'hFF);
        check("R1 outputs", 32'(rst_out), 0);
        // R4: enable without key
        wr(8'hFC, 32'h0000_0005);
        rd(8'hFC, "R4 enable stored", 5, 32'hFF);
        // R2: keyed control write
        wr(8'h18, 32'h8800_0007);
        #2 check("R5 masked output", 32'(rst_out), 5);
        check("R2 no-enable output", 32'(rst_out2), 7);
        // R6: read-back with key byte zero
        rd(8'h18, "R6 ctrl read", 7, 7);
        // R3: wrong keys
        wr(8'h18, 32'h89FF_FFFF);
        wr(8'h18, 32'h08FF_FFFF);
        wr(8'h18, 32'h00FF_FFFF);
        rd(8'h18, "R3 ctrl unchanged", 7, 7);
        // R4: upper byte ignored for enable, high bits dropped
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'hFC, "R4 enable all", 32'h00FF_FFFF, 32'hFF);
        check("R5 all enabled", 32'(rst_out), 7);
        // R9: drop enable under a set control bit
        wr(8'hFC, 32'h00FF_FFFE);
        #2 check("R9 line released", 32'(rst_out), 6);
        rd(8'h18, "R9 ctrl kept", 7, 7);
        wr(8'hFC, 32'h00FF_FFFF);
        #2 check("R9 line reasserted", 32'(rst_out), 7);
        // R8: other offsets
        wr(8'h1C, 32'h88FF_FFFF);
        wr(8'hF8, 32'h88FF_FFFF);
        rd(8'h18, "R8 ctrl unchanged", 7, 7);
        rd(8'h1C, "R8 other read zero", 0, 0);
        rd(8'h04, "R8 other read zero", 0, 0);
        // R2: all lines on
        wr(8'h18, 32'h88FF_FFFF);
        rd(8'h18, "R2 all lines", 32'h00FF_FFFF, 32'hFF);
        check("R5 all asserted", 32'(rst_out), 32'h00FF_FFFF);
        // R7: writes to absent enable ignored
        wr(8'hFC, 32'h0000_0000);
        rd(8'hFC, "R7 absent enable", 0, 32'hFF);
        check("R7 no-enable still asserted", 32'(rst_out2), 32'hFF);
        // Release order: control first, then enable
        wr(8'h18, 32'h8800_0000);
        rd(8'h18, "R2 cleared", 0, 0);
        // R1: reset mid-run
        wr(8'hFC, 32'h0000_00F0);
        wr(8'h18, 32'h8800_00FF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(8'h18, "R1 ctrl cleared", 0, 0);
        rd(8'hFC, "R1 enable cleared", 0, 32'hFF);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        fails++; tests++;
        done = 1'b1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule